// File: doc/BRIEF.md
# Command/Result Phase Handshake Sequencer

This block steers the three phases of a byte-oriented controller: the host writes a command byte and its parameters, an execution engine runs, and the host then reads a fixed number of result bytes. Progress shows on three status bits. `rqm` means the data port is ready for the host. `dio` gives the transfer direction: 0 means host to block, 1 means block to host. `cb` means a command is in progress. An interrupt line marks the start of the result phase.

The first byte is looked up in a small opcode table. The table gives the parameter count, the result count, and whether an external execution engine is needed. An unknown first byte is not echoed back as a result. The block raises the interrupt, stays in the command phase, and keeps the fault so that a later interrupt-query command can report it. The execution engine is outside this block. It gets a start pulse and the opcode, answers with a done pulse, and supplies result bytes selected by an index.

Top module: `hs_seq`

## Requirements
- R1: After reset, `rqm`=1, `dio`=0, `cb`=0, `irq`=0 and `exec_start`=0.
- R2: A write is accepted only when `rqm`=1 and `dio`=0. In the cycle after any accepted write, `rqm` is 0. In the cycle after an accepted valid first byte, `cb` is 1.
- R3: A first byte other than 0x03, 0x04, 0x06 or 0x08 sets `irq` to 1 and leaves `cb` at 0. The block stays in the command phase (`dio`=0, and `rqm` returns to 1).
- R4: Opcode 0x08 takes no parameters. Accepting it clears `irq`. It yields one result byte: 0x80 if an invalid first byte has been seen since the previous 0x08, otherwise 0x00.
- R5: Opcode 0x06 takes 8 parameters and returns 7 results. Opcode 0x04 takes 1 parameter and returns 1 result. Both run the execution engine. Opcode 0x03 takes 2 parameters, returns no results and runs no engine. After its last parameter the block goes back to `cb`=0, `dio`=0 without raising `irq`.
- R6: Once the last parameter of 0x06 or 0x04 is accepted, `exec_start` pulses for exactly one cycle with `exec_opcode` equal to the opcode. `rqm` stays 0 until `exec_done`.
- R7: The cycle after `exec_done` is sampled in execution, `irq`=1, `rqm`=1 and `dio`=1.
- R8: A read is accepted only when `rqm`=1 and `dio`=1. Result byte k (counting from 0) is `res_byte` while `res_sel`=k, and appears on `rd_data`. A read outside the result phase has no effect.
- R9: A write during execution or during the result phase is ignored. The full set of result bytes is still delivered.
- R10: `irq` is 0 in the cycle after the first result byte is read.
- R11: After the last result byte is read: `rqm`=1, `dio`=0, `cb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host command or parameter byte |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Result byte to the host (0 outside the result phase) |
| rqm | output | 1 | Data port ready for the host |
| dio | output | 1 | Direction: 1 = block to host |
| cb | output | 1 | Command in progress |
| irq | output | 1 | Interrupt, marks the result phase or an invalid command |
| exec_start | output | 1 | One-cycle start pulse to the execution engine |
| exec_opcode | output | 8 | Opcode of the running command |
| exec_done | input | 1 | Execution finished |
| res_sel | output | 4 | Index of the result byte being presented |
| res_byte | input | 8 | Result byte supplied by the execution engine |

## Verification
The bench drives writes into execution and into a pending result phase. A sequencer that did not gate writes on `rqm`/`dio` would restart, shorten the result count, or treat a stray byte as a parameter. It runs invalid opcodes before and between queries, so a fault flag that never clears, or that is lost when a valid command runs in between, gives a wrong 0x80/0x00 query byte. It checks the parameter-only opcode, which must close without an interrupt, and it checks that every result index arrives in order. A counter off by one would return a byte too few or too many and leave `dio` stuck.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    localparam logic [BYTE_W-1:0] OP_MOVE   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_PROBE  = 8'h04;
    localparam logic [BYTE_W-1:0] OP_CONFIG = 8'h03;
    localparam logic [BYTE_W-1:0] OP_QUERY  = 8'h08;

    localparam logic [BYTE_W-1:0] ST_BADCMD = 8'h80;
    localparam logic [BYTE_W-1:0] ST_CLEAN  = 8'h00;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_PARAM,
        PH_EXEC,
        PH_RESULT
    } phase_e;

    typedef struct packed {
        logic             valid;
        logic             local_res;
        logic             run_exec;
        logic [CNT_W-1:0] n_param;
        logic [CNT_W-1:0] n_result;
    } op_info_t;

    function automatic op_info_t op_lookup(input logic [BYTE_W-1:0] op);
        op_info_t t;
        t = '0;
        case (op)
            OP_MOVE:   begin t.valid = 1'b1; t.run_exec = 1'b1; t.n_param = 4'd8; t.n_result = 4'd7; end
            OP_PROBE:  begin t.valid = 1'b1; t.run_exec = 1'b1; t.n_param = 4'd1; t.n_result = 4'd1; end
            OP_CONFIG: begin t.valid = 1'b1; t.n_param = 4'd2; end
            OP_QUERY:  begin t.valid = 1'b1; t.local_res = 1'b1; t.n_result = 4'd1; end
            default:   t = '0;
        endcase
        return t;
    endfunction

    function automatic phase_e post_param(input op_info_t t);
        if (t.run_exec)
            return PH_EXEC;
        else if (t.n_result != '0)
            return PH_RESULT;
        else
            return PH_CMD;
    endfunction

endpackage

// File: rtl/hs_op_decode.sv
module hs_op_decode
    import hs_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_info_t          info
);
    always_comb begin
        info = op_lookup(opcode);
        if (info.local_res)
            assert (info.n_param == '0 && !info.run_exec)
                else $error("p_query_shape_r4: locally answered opcode must take no parameters");
    end
endmodule

// File: rtl/hs_phase_ctrl.sv
module hs_phase_ctrl
    import hs_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [BYTE_W-1:0] wr_data,
    input  op_info_t          dec,
    input  logic              rd_fire,
    input  logic              exec_done,
    output phase_e            phase,
    output logic              taking,
    output logic              irq,
    output logic              exec_start,
    output logic [BYTE_W-1:0] cur_op,
    output op_info_t          cur,
    output logic [CNT_W-1:0]  cnt,
    output logic [BYTE_W-1:0] local_byte
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic   bad_seen;
    phase_e first_next;

    assign first_next = post_param(dec);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_CMD;
            taking     <= 1'b0;
            irq        <= 1'b0;
            bad_seen   <= 1'b0;
            exec_start <= 1'b0;
            cur_op     <= '0;
            cur        <= '0;
            cnt        <= '0;
            local_byte <= ST_CLEAN;
        end else begin
            taking     <= wr_fire;
            exec_start <= 1'b0;
            case (phase)
                PH_CMD: begin
                    if (wr_fire) begin
                        if (!dec.valid) begin
                            irq      <= 1'b1;
                            bad_seen <= 1'b1;
                        end else begin
                            cur    <= dec;
                            cur_op <= wr_data;
                            cnt    <= '0;
                            if (dec.n_param != '0) begin
                                phase <= PH_PARAM;
                            end else begin
                                phase <= first_next;
                                if (dec.local_res) begin
                                    irq        <= 1'b0;
                                    local_byte <= bad_seen ? ST_BADCMD : ST_CLEAN;
                                    bad_seen   <= 1'b0;
                                end else if (first_next == PH_RESULT) begin
                                    irq <= 1'b1;
                                end
                                if (first_next == PH_EXEC)
                                    exec_start <= 1'b1;
                            end
                        end
                    end
                end
                PH_PARAM: begin
                    if (wr_fire) begin
                        if (cnt == cur.n_param - ONE) begin
                            cnt   <= '0;
                            phase <= post_param(cur);
                            if (post_param(cur) == PH_EXEC)
                                exec_start <= 1'b1;
                            if (post_param(cur) == PH_RESULT)
                                irq <= 1'b1;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
                PH_EXEC: begin
                    if (exec_done) begin
                        phase <= PH_RESULT;
                        irq   <= 1'b1;
                        cnt   <= '0;
                    end
                end
                PH_RESULT: begin
                    if (rd_fire) begin
                        if (cnt == '0)
                            irq <= 1'b0;
                        if (cnt == cur.n_result - ONE) begin
                            phase <= PH_CMD;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
                default: phase <= PH_CMD;
            endcase
        end
    end

    p_invalid_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD && wr_fire && !dec.valid) |=> (irq && phase == PH_CMD));

    p_query_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD && wr_fire && dec.valid && dec.local_res) |=> (!irq && phase == PH_RESULT));

    p_start_once_r6: assert property (@(posedge clk) disable iff (rst)
        exec_start |-> (phase == PH_EXEC && !$past(exec_start)));

    p_done_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && exec_done) |=> (irq && phase == PH_RESULT));

    p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RESULT && !rd_fire) |=> (phase == PH_RESULT && $stable(cnt)));

    p_irq_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RESULT && rd_fire && cnt == '0) |=> !irq);

    p_last_read_r11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RESULT && rd_fire && cnt == cur.n_result - ONE) |=> phase == PH_CMD);
endmodule

// File: rtl/hs_read_mux.sv
module hs_read_mux
    import hs_seq_pkg::*;
(
    input  phase_e            phase,
    input  logic              use_local,
    input  logic [BYTE_W-1:0] local_byte,
    input  logic [BYTE_W-1:0] ext_byte,
    output logic [BYTE_W-1:0] rd_data
);
    always_comb begin
        if (phase != PH_RESULT)
            rd_data = '0;
        else if (use_local)
            rd_data = local_byte;
        else
            rd_data = ext_byte;
    end
endmodule

// File: rtl/hs_seq.sv
module hs_seq
    import hs_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rqm,
    output logic              dio,
    output logic              cb,
    output logic              irq,
    output logic              exec_start,
    output logic [BYTE_W-1:0] exec_opcode,
    input  logic              exec_done,
    output logic [CNT_W-1:0]  res_sel,
    input  logic [BYTE_W-1:0] res_byte
);
    op_info_t          dec;
    op_info_t          cur;
    phase_e            phase;
    logic              taking;
    logic              wr_fire;
    logic              rd_fire;
    logic [BYTE_W-1:0] local_byte;

    assign rqm     = (phase != PH_EXEC) && !taking;
    assign dio     = (phase == PH_RESULT);
    assign cb      = (phase != PH_CMD);
    assign wr_fire = wr_en && rqm && !dio;
    assign rd_fire = rd_en && rqm && dio;

    hs_op_decode u_dec (
        .opcode (wr_data),
        .info   (dec)
    );

    hs_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_fire    (wr_fire),
        .wr_data    (wr_data),
        .dec        (dec),
        .rd_fire    (rd_fire),
        .exec_done  (exec_done),
        .phase      (phase),
        .taking     (taking),
        .irq        (irq),
        .exec_start (exec_start),
        .cur_op     (exec_opcode),
        .cur        (cur),
        .cnt        (res_sel),
        .local_byte (local_byte)
    );

    hs_read_mux u_mux (
        .phase      (phase),
        .use_local  (cur.local_res),
        .local_byte (local_byte),
        .ext_byte   (res_byte),
        .rd_data    (rd_data)
    );

    p_take_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rqm && !dio) |=> !rqm);

    p_exec_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        exec_start |-> (!rqm && cb));
endmodule

// File: tb/hs_seq_tb.sv
module hs_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rqm, dio, cb, irq, exec_start;
    logic [7:0] exec_opcode;
    logic       exec_done = 1'b0;
    logic [3:0] res_sel;
    logic [7:0] res_byte;
    logic [7:0] salt = 8'h5A;

    int checks = 0;
    int errors = 0;
    bit bad_model = 1'b0;

    always #2.5 clk = ~clk;

    assign res_byte = salt + {4'h0, res_sel} * 8'h1D;

    hs_seq u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rqm(rqm), .dio(dio), .cb(cb), .irq(irq),
        .exec_start(exec_start), .exec_opcode(exec_opcode), .exec_done(exec_done),
        .res_sel(res_sel), .res_byte(res_byte)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_params(input logic [7:0] op);
        case (op) 8'h06: return 8; 8'h04: return 1; 8'h03: return 2; default: return 0; endcase
    endfunction
    function automatic int exp_results(input logic [7:0] op);
        case (op) 8'h06: return 7; 8'h04: return 1; 8'h08: return 1; default: return 0; endcase
    endfunction
    function automatic bit is_known(input logic [7:0] op);
        return op == 8'h06 || op == 8'h04 || op == 8'h03 || op == 8'h08;
    endfunction
    function automatic logic [7:0] exp_byte(input logic [7:0] s, input int k);
        return s + 8'(k) * 8'h1D;
    endfunction

    // Execution stub: random latency, rqm must stay low meanwhile
    initial begin
        forever begin
            @(negedge clk);
            if (exec_start) begin
                for (int d = 3 + int'($urandom % 10); d > 0; d--) begin
                    check(rqm == 1'b0, "R6 rqm low in execution", rqm, 0);
                    @(negedge clk);
                end
                exec_done = 1'b1;
                @(negedge clk);
                exec_done = 1'b0;
            end
        end
    end

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        while (!(rqm && !dio)) @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        check(rqm == 1'b0, "R2 rqm low after accepted write", rqm, 0);
    endtask

    task automatic poke_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        @(negedge clk);
        while (!(rqm && dio)) @(negedge clk);
        b = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_cmd(input logic [7:0] op, input bit poke_result);
        logic [7:0] got;
        int np, nr;
        np = exp_params(op);
        nr = exp_results(op);
        salt = 8'($urandom);
        write_byte(op);
        if (!is_known(op)) begin
            check(irq == 1'b1, "R3 irq on invalid opcode", irq, 1);
            check(cb == 1'b0, "R3 cb stays low on invalid", cb, 0);
            @(negedge clk);
            check(rqm && !dio, "R3 back in command phase", {rqm, dio}, 2'b10);
            bad_model = 1'b1;
            return;
        end
        check(cb == 1'b1, "R2 cb set after valid first byte", cb, 1);
        if (op == 8'h08) begin
            check(irq == 1'b0, "R4 irq cleared by query", irq, 0);
            read_byte(got);
            check(got == (bad_model ? 8'h80 : 8'h00), "R4 query status byte", got, bad_model ? 8'h80 : 8'h00);
            bad_model = 1'b0;
            @(negedge clk);
            check(rqm && !dio && !cb, "R11 idle after query read", {rqm, dio, cb}, 3'b100);
            return;
        end
        for (int i = 0; i < np; i++) write_byte(8'($urandom));
        if (op == 8'h03) begin
            @(negedge clk);
            check(!cb && !dio && rqm, "R5 parameter-only opcode closes", {rqm, dio, cb}, 3'b100);
            return;
        end
        check(exec_start == 1'b1, "R6 exec_start pulse", exec_start, 1);
        check(exec_opcode == op, "R6 exec_opcode", exec_opcode, op);
        poke_write(8'h08);
        check(exec_start == 1'b0, "R6 exec_start one cycle", exec_start, 0);
        poke_write(8'h03);
        while (!dio) @(negedge clk);
        check(irq && rqm, "R7 result phase entry", {irq, rqm}, 2'b11);
        if (poke_result) begin
            poke_write(8'h06);
            @(negedge clk);
            check(dio && rqm && cb, "R9 write in result phase ignored", {rqm, dio, cb}, 3'b111);
        end
        for (int k = 0; k < nr; k++) begin
            read_byte(got);
            check(got == exp_byte(salt, k), "R8 result byte", got, exp_byte(salt, k));
            if (k == 0) check(irq == 1'b0, "R10 irq cleared on first read", irq, 0);
            if (k < nr - 1) check(dio == 1'b1, "R5 more results pending", dio, 1);
        end
        check(rqm && !dio && !cb, "R11 ready after last result", {rqm, dio, cb}, 3'b100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({rqm, dio, cb, irq, exec_start} == 5'b10000, "R1 reset state",
              {rqm, dio, cb, irq, exec_start}, 5'b10000);
        // read outside result phase has no effect
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rqm && !dio && !cb && rd_data == 8'h00, "R8 stray read ignored", {rqm, dio, cb}, 3'b100);
        // directed corner cases
        run_cmd(8'h08, 1'b0);
        run_cmd(8'hFF, 1'b0);
        run_cmd(8'h06, 1'b1);
        run_cmd(8'h08, 1'b0);
        run_cmd(8'h03, 1'b0);
        run_cmd(8'h04, 1'b1);
        // constrained random mix
        for (int n = 0; n < 40; n++) begin
            case ($urandom % 5)
                0: run_cmd(8'h06, 1'($urandom));
                1: run_cmd(8'h04, 1'($urandom));
                2: run_cmd(8'h03, 1'b0);
                3: run_cmd(8'h08, 1'b0);
                default: begin
                    do r = 8'($urandom); while (is_known(r));
                    run_cmd(r, 1'b0);
                end
            endcase
        end
        run_cmd(8'h08, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule